// File: doc/BRIEF.md
# Touch Coordinate Trimmed Averager

This block turns one touch-measurement frame into a filtered X and Y coordinate. A frame arrives as a stream of words on a valid/ready input. The words are, in order: N samples of the Y axis, two pressure samples, and N samples of the X axis. N is the readout count set on a configuration input. Only the low 12 bits of each word carry sample data.

For each axis the block keeps a running sum, minimum and maximum. When N is above three it subtracts the smallest and the largest sample from the sum and divides the rest by N-2. This trimmed mean rejects one outlier at each end without sorting. When N is three or less it divides the full sum by N. A small shared sequential divider computes both quotients. The result is presented with a one-cycle valid pulse. The next frame is accepted only after that pulse.

Top module: `touch_trim_avg`

## Requirements
- R1: While reset is asserted and until a whole frame has been received, `out_valid` is low; `in_ready` is low during reset.
- R2: A frame is exactly 2N+2 accepted words (a word is accepted when `in_valid` and `in_ready` are both high in the same cycle). Words 0..N-1 are Y samples, words N and N+1 are pressure samples, and words N+2..2N+1 are X samples. No output appears before the last word of a frame.
- R3: Only bits [11:0] of `in_data` are used as a sample. Bits [31:12] have no effect on the result.
- R4: For N of 4 to 7, each coordinate equals floor((sum - min - max) / (N-2)) over that axis's N samples.
- R5: For N of 1 to 3, each coordinate equals floor(sum / N) over that axis's N samples.
- R6: The two pressure words have no effect on `out_x` or `out_y`.
- R7: `out_valid` is high for exactly one cycle per frame, with `out_x` and `out_y` valid in that cycle. `in_ready` stays low from the cycle after the last word of a frame is accepted until after the `out_valid` cycle.
- R8: `cfg_readouts` is sampled once, at the start of each frame. Changes to it during a frame have no effect on that frame.
- R9: A `cfg_readouts` value of 0 is treated as N = 1, which gives a 4-word frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_readouts | input | 3 | Readouts per axis N (0 treated as 1) |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word; sample in bits [11:0] |
| in_ready | output | 1 | Block accepts a word this cycle |
| out_valid | output | 1 | One-cycle pulse: coordinates valid |
| out_x | output | 12 | Averaged X coordinate |
| out_y | output | 12 | Averaged Y coordinate |

## Verification
Directed frames cover the boundary counts N = 0, 1, 3, 4 and 7. These separate the plain-mean path from the trimmed-mean path and expose a wrong divisor. Further directed frames use all-zero samples, all-full-scale samples, equal samples, and a single outlier in each axis. These show whether min and max are subtracted, whether the sum overflows, and whether the division truncates. Extreme pressure words, random upper bits, and a readout count changed in the middle of a frame show that those inputs are ignored. Random frames with random N and random input gaps then catch mistakes in the Y/pressure/X word positions and in the handshake.

// File: rtl/ttavg_pkg.sv
package ttavg_pkg;

    typedef enum logic [2:0] {
        ST_LOAD    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_DIV_Y   = 3'd2,
        ST_DIV_X   = 3'd3,
        ST_EMIT    = 3'd4
    } ttavg_state_e;

    localparam int AXIS_Y = 0;
    localparam int AXIS_X = 1;
    localparam int NUM_AXES = 2;

endpackage

// File: rtl/ttavg_axis_acc.sv
module ttavg_axis_acc #(
    parameter int SAMPLE_W = 12,
    parameter int SUM_W    = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SUM_W-1:0]    sum,
    output logic [SAMPLE_W-1:0] min_val,
    output logic [SAMPLE_W-1:0] max_val
);

    typedef struct packed {
        logic [SUM_W-1:0]    sum;
        logic [SAMPLE_W-1:0] mn;
        logic [SAMPLE_W-1:0] mx;
        logic                seen;
    } acc_t;

    acc_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.sum  = '0;
            r_d.mn   = '1;
            r_d.mx   = '0;
            r_d.seen = 1'b0;
        end else if (en) begin
            r_d.sum  = r_q.sum + SUM_W'(sample);
            r_d.seen = 1'b1;
            if (sample < r_q.mn) r_d.mn = sample;
            if (sample > r_q.mx) r_d.mx = sample;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sum  <= '0;
            r_q.mn   <= '1;
            r_q.mx   <= '0;
            r_q.seen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sum     = r_q.sum;
    assign min_val = r_q.mn;
    assign max_val = r_q.mx;

    // R4: the extremes tracked for trimming must bracket every sample seen
    a_r4_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.seen |-> (r_q.mn <= r_q.mx));

    // R4: the running sum is never below the largest sample taken in
    a_r4_sum_ge_max: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.seen |-> (r_q.sum >= SUM_W'(r_q.mx)));

endmodule

// File: rtl/ttavg_divider.sv
module ttavg_divider #(
    parameter int NUM_W = 15,
    parameter int DEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic             done,
    output logic [NUM_W-1:0] quot
);

    localparam int CNT_W  = $clog2(NUM_W);
    localparam int PROD_W = NUM_W + DEN_W + 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
        logic [NUM_W-1:0] num;
    } div_t;

    div_t r_q, r_d;
    logic [DEN_W:0] shifted;
    logic [DEN_W:0] diff;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        shifted  = {r_q.rem, r_q.quo[NUM_W-1]};
        diff     = shifted - {1'b0, r_q.den};
        if (start && !r_q.busy) begin
            r_d.busy = 1'b1;
            r_d.cnt  = CNT_W'(NUM_W - 1);
            r_d.rem  = '0;
            r_d.quo  = numer;
            r_d.den  = denom;
            r_d.num  = numer;
        end else if (r_q.busy) begin
            if (shifted >= {1'b0, r_q.den}) begin
                r_d.rem = diff[DEN_W-1:0];
                r_d.quo = {r_q.quo[NUM_W-2:0], 1'b1};
            end else begin
                r_d.rem = shifted[DEN_W-1:0];
                r_d.quo = {r_q.quo[NUM_W-2:0], 1'b0};
            end
            if (r_q.cnt == '0) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done = r_q.done;
    assign quot = r_q.quo;

    // R4, R5: a finished quotient is the truncated one: q*d <= n < (q+1)*d
    a_r5_quot_exact: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> ((PROD_W'(r_q.quo) * PROD_W'(r_q.den) <= PROD_W'(r_q.num)) &&
                      (PROD_W'(r_q.num) < (PROD_W'(r_q.quo) + 1'b1) * PROD_W'(r_q.den))));

    // R4, R5: the divisor is never zero once a division is running
    a_r4_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> (r_q.den != '0));

endmodule

// File: rtl/touch_trim_avg.sv
module touch_trim_avg #(
    parameter int DATA_W   = 32,
    parameter int SAMPLE_W = 12,
    parameter int MAX_N    = 7,
    parameter int TRIM_MIN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cfg_readouts,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    output logic                in_ready,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_x,
    output logic [SAMPLE_W-1:0] out_y
);
    import ttavg_pkg::*;

    localparam int N_W   = $clog2(MAX_N + 1);
    localparam int SUM_W = SAMPLE_W + N_W;
    localparam int IDX_W = $clog2(2 * MAX_N + 2);

    typedef struct packed {
        ttavg_state_e        st;
        logic [N_W-1:0]      n;
        logic                trim;
        logic [IDX_W-1:0]    idx;
        logic                div_start;
        logic                out_valid;
        logic [SAMPLE_W-1:0] x;
        logic [SAMPLE_W-1:0] y;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [N_W-1:0]      n_cfg;
    logic                take;
    logic [IDX_W-1:0]    last_idx;
    logic [IDX_W-1:0]    x_first;
    logic [SAMPLE_W-1:0] sample;
    logic                acc_clear;
    logic [NUM_AXES-1:0] acc_en;
    logic [SUM_W-1:0]    acc_sum [NUM_AXES];
    logic [SAMPLE_W-1:0] acc_min [NUM_AXES];
    logic [SAMPLE_W-1:0] acc_max [NUM_AXES];
    logic [SUM_W-1:0]    net_sum [NUM_AXES];
    logic [SUM_W-1:0]    div_num;
    logic [N_W-1:0]      div_den;
    logic                div_done;
    logic [SUM_W-1:0]    div_quot;

    assign n_cfg    = (N_W'(cfg_readouts) == '0) ? N_W'(1) : N_W'(cfg_readouts);
    assign in_ready = (r_q.st == ST_COLLECT);
    assign take     = in_valid && in_ready;
    assign last_idx = IDX_W'({r_q.n, 1'b1});
    assign x_first  = IDX_W'(r_q.n) + IDX_W'(2);
    assign sample   = in_data[SAMPLE_W-1:0];
    assign acc_clear = (r_q.st == ST_LOAD);
    assign acc_en[AXIS_Y] = take && (r_q.idx < IDX_W'(r_q.n));
    assign acc_en[AXIS_X] = take && (r_q.idx >= x_first);

    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
            ttavg_axis_acc #(
                .SAMPLE_W(SAMPLE_W),
                .SUM_W   (SUM_W)
            ) u_acc (
                .clk    (clk),
                .rst_n  (rst_n),
                .clear  (acc_clear),
                .en     (acc_en[a]),
                .sample (sample),
                .sum    (acc_sum[a]),
                .min_val(acc_min[a]),
                .max_val(acc_max[a])
            );
            assign net_sum[a] = r_q.trim
                ? acc_sum[a] - SUM_W'(acc_min[a]) - SUM_W'(acc_max[a])
                : acc_sum[a];
        end
    endgenerate

    assign div_num = (r_q.st == ST_DIV_Y) ? net_sum[AXIS_Y] : net_sum[AXIS_X];
    assign div_den = r_q.trim ? (r_q.n - N_W'(2)) : r_q.n;

    ttavg_divider #(
        .NUM_W(SUM_W),
        .DEN_W(N_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(r_q.div_start),
        .numer(div_num),
        .denom(div_den),
        .done (div_done),
        .quot (div_quot)
    );

    always_comb begin
        r_d           = r_q;
        r_d.div_start = 1'b0;
        r_d.out_valid = 1'b0;
        unique case (r_q.st)
            ST_LOAD: begin
                r_d.n    = n_cfg;
                r_d.trim = (n_cfg >= N_W'(TRIM_MIN));
                r_d.idx  = '0;
                r_d.st   = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (take) begin
                    if (r_q.idx == last_idx) begin
                        r_d.st        = ST_DIV_Y;
                        r_d.div_start = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_DIV_Y: begin
                if (div_done) begin
                    r_d.y         = div_quot[SAMPLE_W-1:0];
                    r_d.div_start = 1'b1;
                    r_d.st        = ST_DIV_X;
                end
            end
            ST_DIV_X: begin
                if (div_done) begin
                    r_d.x         = div_quot[SAMPLE_W-1:0];
                    r_d.out_valid = 1'b1;
                    r_d.st        = ST_EMIT;
                end
            end
            ST_EMIT: begin
                r_d.st = ST_LOAD;
            end
            default: begin
                r_d.st = ST_LOAD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st        <= ST_LOAD;
            r_q.n         <= N_W'(1);
            r_q.trim      <= 1'b0;
            r_q.idx       <= '0;
            r_q.div_start <= 1'b0;
            r_q.out_valid <= 1'b0;
            r_q.x         <= '0;
            r_q.y         <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.out_valid;
    assign out_x     = r_q.x;
    assign out_y     = r_q.y;

    // R7: the result pulse lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7: no word is taken while a result is being presented
    a_r7_no_ready_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R8: the latched readout count holds for the whole collection phase
    a_r8_n_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && $past(in_ready)) |-> $stable(r_q.n));

    // R2: the word index never runs past the last word of the frame
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (r_q.idx <= last_idx));

    // R4: trimming only happens when enough samples make min+max part of the sum
    a_r4_trim_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.trim && (r_q.st == ST_DIV_Y)) |->
            (acc_sum[AXIS_Y] >= SUM_W'(acc_min[AXIS_Y]) + SUM_W'(acc_max[AXIS_Y])));

    // R9: a zero count still gives a non-empty frame
    a_r9_n_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (r_q.n != '0));

endmodule

// File: tb/tb_touch_trim_avg.sv
module tb_touch_trim_avg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_readouts = 3'd1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [11:0] out_x;
    logic [11:0] out_y;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic done_flag = 1'b0;

    int ys [7];
    int xs [7];

    always #2 clk = ~clk;

    touch_trim_avg dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_readouts(cfg_readouts),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_x       (out_x),
        .out_y       (out_y)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_n(input int cfg);
        return (cfg == 0) ? 1 : cfg;
    endfunction

    function automatic int axis_avg(input int v [7], input int cfg);
        int n = eff_n(cfg);
        int s = 0;
        int mn = 4095;
        int mx = 0;
        for (int i = 0; i < n; i++) begin
            s += v[i];
            if (v[i] < mn) mn = v[i];
            if (v[i] > mx) mx = v[i];
        end
        if (n > 3) return (s - mn - mx) / (n - 2);
        return s / n;
    endfunction

    task automatic send_word(input int sample, input bit rand_hi, output bit early);
        bit rdy;
        int gap = int'($urandom_range(0, 2));
        early = 1'b0;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (out_valid) early = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {(rand_hi ? 20'($urandom()) : 20'h0), 12'(sample)};
        rdy = in_ready;
        if (out_valid) early = 1'b1;
        while (!rdy) begin
            @(negedge clk);
            rdy = in_ready;
            if (out_valid) early = 1'b1;
        end
        @(posedge clk);
    endtask

    task automatic run_frame(input int cfg, input int next_cfg, input int p0, input int p1,
                             input bit scramble, input string tag);
        int  n = eff_n(cfg);
        int  exp_x = axis_avg(xs, cfg);
        int  exp_y = axis_avg(ys, cfg);
        bit  early;
        bit  any_early = 1'b0;
        bit  rdy_bad = 1'b0;
        int  wait_cnt = 0;
        for (int i = 0; i < n; i++) begin
            send_word(ys[i], 1'b1, early);
            any_early |= early;
            if (scramble && i == 0) cfg_readouts = 3'($urandom_range(0, 7));
        end
        send_word(p0, 1'b1, early); any_early |= early;
        send_word(p1, 1'b1, early); any_early |= early;
        for (int i = 0; i < n; i++) begin
            send_word(xs[i], 1'b1, early);
            any_early |= early;
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid && wait_cnt < 200) begin
            if (in_ready) rdy_bad = 1'b1;
            @(negedge clk);
            wait_cnt++;
        end
        if (in_ready) rdy_bad = 1'b1;
        check(!any_early, {tag, " R2 no output before frame end"}, int'(any_early), 0);
        check(out_valid, {tag, " R7 out_valid pulse seen"}, int'(out_valid), 1);
        check(int'(out_x) == exp_x, {tag, " R4/R5 x value"}, int'(out_x), exp_x);
        check(int'(out_y) == exp_y, {tag, " R4/R5 y value"}, int'(out_y), exp_y);
        check(!rdy_bad, {tag, " R7 ready low until output"}, int'(rdy_bad), 0);
        cfg_readouts = 3'(next_cfg);
        @(negedge clk);
        check(!out_valid, {tag, " R7 pulse one cycle"}, int'(out_valid), 0);
    endtask

    task automatic fill(input int yv, input int xv);
        for (int i = 0; i < 7; i++) begin
            ys[i] = yv;
            xs[i] = xv;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        cfg_readouts = 3'd1;
        repeat (3) @(negedge clk);
        check(!out_valid, "R1 out_valid low in reset", int'(out_valid), 0);
        check(!in_ready, "R1 in_ready low in reset", int'(in_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!out_valid, "R1 out_valid low after reset", int'(out_valid), 0);

        // N = 1 plain mean
        fill(0, 0); ys[0] = 1234; xs[0] = 4000;
        run_frame(1, 0, 0, 0, 1'b0, "R5 n1");
        // N = 0 treated as 1
        fill(0, 0); ys[0] = 77; xs[0] = 4095;
        run_frame(0, 3, 4095, 4095, 1'b0, "R9 n0");
        // N = 3 plain mean with truncation, outlier not removed
        fill(0, 0); ys[0] = 10; ys[1] = 11; ys[2] = 4000; xs[0] = 1; xs[1] = 1; xs[2] = 2;
        run_frame(3, 4, 0, 4095, 1'b0, "R5 n3");
        // N = 4 trimmed mean boundary
        fill(0, 0); ys[0] = 4095; ys[1] = 100; ys[2] = 103; ys[3] = 0;
        xs[0] = 5; xs[1] = 7; xs[2] = 4000; xs[3] = 6;
        run_frame(4, 7, 123, 3210, 1'b0, "R4 n4");
        // N = 7 full scale, sum width
        fill(4095, 4095);
        run_frame(7, 7, 0, 0, 1'b0, "R4 n7 full");
        // N = 7 all zero with extreme pressure
        fill(0, 0);
        run_frame(7, 5, 4095, 4095, 1'b0, "R6 n7 zero");
        // N = 5 equal values, min and max duplicates
        fill(2048, 1);
        run_frame(5, 6, 4095, 0, 1'b0, "R4 n5 equal");
        // N = 6 with readout count changed during the frame
        for (int i = 0; i < 7; i++) begin
            ys[i] = int'($urandom_range(0, 4095));
            xs[i] = int'($urandom_range(0, 4095));
        end
        run_frame(6, 2, 1, 2, 1'b1, "R8 n6 cfg change");
        // N = 2 plain mean
        run_frame(2, 4, 9, 9, 1'b0, "R5 n2");

        // random frames (upper word bits random in every word: R3)
        for (int f = 0; f < 40; f++) begin
            int cur;
            int nxt;
            cur = int'(cfg_readouts);
            nxt = int'($urandom_range(0, 7));
            for (int i = 0; i < 7; i++) begin
                ys[i] = int'($urandom_range(0, 4095));
                xs[i] = int'($urandom_range(0, 4095));
            end
            run_frame(cur, nxt, int'($urandom_range(0, 4095)),
                      int'($urandom_range(0, 4095)), f[0], "R3 random");
        end

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule